// File: doc/BRIEF.md
# Synchronous Four-Channel Slave FIFO Port

This block is the outward-facing side of four packet FIFOs, clocked by an interface clock. An external bus master chooses one FIFO through a 2-bit select. It then moves words over a 16-bit data path, which can be narrowed to 8 bits, using read, write, output-enable and packet-end strobes. An optional chip select gates all of these strobes. Every strobe has its own polarity setting. The read data is driven only while output-enable is active. The status flags always describe the selected FIFO, apart from one watch flag that tracks a FIFO chosen by configuration.

Write data builds up a pending packet in the selected FIFO, counted in bytes. The pending packet is committed when its byte count reaches the configured packet length, or earlier when the master asserts packet-end. Each commit is reported on a one-cycle event output that gives the FIFO number and the byte count. This event is how the internal side learns that a packet is ready.

Top module: `slave_fifo_port`

## Requirements
- R1: `fifo_sel` selects which FIFO the strobes act on. `bus_out`, `flag_empty` and `flag_full` always reflect the FIFO currently selected.
- R2: With `cfg_wide`=1 a write stores all 16 bits and adds 2 bytes to the pending count. With `cfg_wide`=0 a write stores only `bus_in[7:0]`, the stored upper byte reads as 0, and the write adds 1 byte.
- R3: At each rising edge where write is effective and the selected FIFO is not full, `bus_in` is appended to that FIFO.
- R4: While output-enable is effective and read is not, `bus_out` shows the oldest word and does not advance. At each edge where read is effective and the FIFO is not empty, the next word appears on `bus_out` right after that edge.
- R5: `bus_drive` is 1 only while output-enable is effective. Otherwise `bus_out` is all zeros.
- R6: A write to a full FIFO and a read from an empty FIFO have no effect. Stored data, order and occupancy are left unchanged.
- R7: An effective packet-end commits the pending bytes. In the cycle after that edge, `commit_valid`=1 with `commit_fifo` and `commit_bytes` set. A packet-end with nothing pending produces no commit.
- R8: A write that brings the pending count to `cfg_pkt_len` or above commits the packet automatically. A write and a packet-end on the same edge produce a single commit that includes that write.
- R9: `cfg_pol` bit 0 = read, 1 = write, 2 = output-enable, 3 = packet-end, 4 = chip select. A bit value of 1 makes that strobe active-high, and 0 makes it active-low.
- R10: With `cfg_cs_use`=1, no strobe takes effect unless `sl_cs` is at its active level. With `cfg_cs_use`=0, `sl_cs` is ignored.
- R11: `flag_empty` is 1 when the selected FIFO holds no words. `flag_full` is 1 when it holds DEPTH words. `flag_watch` is the full status of FIFO `cfg_watch`, whatever FIFO is selected.
- R12: After reset, all FIFOs are empty, nothing is pending, `commit_valid`=0 and `bus_drive`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_pol | input | 5 | Strobe polarity bits (R9) |
| cfg_cs_use | input | 1 | Chip select takes part in gating |
| cfg_wide | input | 1 | 1 = 16-bit path, 0 = 8-bit path |
| cfg_pkt_len | input | LEN_W | Auto-commit length in bytes |
| cfg_watch | input | 2 | FIFO tracked by flag_watch |
| fifo_sel | input | 2 | FIFO select from the master |
| sl_cs | input | 1 | Chip select pin |
| sl_rd | input | 1 | Read strobe pin |
| sl_wr | input | 1 | Write strobe pin |
| sl_oe | input | 1 | Output-enable pin |
| sl_pktend | input | 1 | Packet-end strobe pin |
| bus_in | input | DATA_W | Write data from the master |
| bus_out | output | DATA_W | Read data toward the master |
| bus_drive | output | 1 | Pad drive enable for bus_out |
| flag_empty | output | 1 | Selected FIFO is empty |
| flag_full | output | 1 | Selected FIFO is full |
| flag_watch | output | 1 | Watched FIFO is full |
| commit_valid | output | 1 | Packet committed on the last edge |
| commit_fifo | output | 2 | FIFO of that commit |
| commit_bytes | output | LEN_W+1 | Byte count of that commit |

## Verification
A corrupted read or write pointer shows up on `bus_out` at the next peek as a word that is out of order or repeated. A wrong occupancy count shows on `flag_empty` or `flag_full` one edge after the strobe that caused it. A pending byte counter that drifts shows as a `commit_bytes` value that is too large, or as an auto-commit that comes too early or too late. Either of these appears at the first commit after the fault. Strobe gating errors show in the same cycle as a `bus_drive` level that is wrong, or as a flag that changes when it should not.

// File: rtl/slfifo_pkg.sv
// Shared types for the slave FIFO port.
// Assumes: polarity vector bit order is read, write, output-enable, packet-end, chip select.
package slfifo_pkg;
    localparam int unsigned POL_RD = 0;
    localparam int unsigned POL_WR = 1;
    localparam int unsigned POL_OE = 2;
    localparam int unsigned POL_PE = 3;
    localparam int unsigned POL_CS = 4;
    localparam int unsigned POL_W  = 5;

    typedef struct packed {
        logic rd;
        logic wr;
        logic oe;
        logic pe;
    } strobe_t;
endpackage

// File: rtl/slfifo_strobe_decode.sv
// Turns raw strobe pins into active-true enables.
// Applies per-strobe polarity and optional chip-select gating. Purely combinational.
// Assumes: pins are already synchronous to the interface clock.
module slfifo_strobe_decode
    import slfifo_pkg::*;
(
    input  logic [POL_W-1:0] pol,
    input  logic             cs_use,
    input  logic             cs_pin,
    input  logic             rd_pin,
    input  logic             wr_pin,
    input  logic             oe_pin,
    input  logic             pe_pin,
    output strobe_t          act
);
    logic cs_ok;

    // Chip select passes when unused or when at its active level.
    always_comb begin
        cs_ok  = !cs_use || (cs_pin == pol[POL_CS]);
        act.rd = cs_ok && (rd_pin == pol[POL_RD]);
        act.wr = cs_ok && (wr_pin == pol[POL_WR]);
        act.oe = cs_ok && (oe_pin == pol[POL_OE]);
        act.pe = cs_ok && (pe_pin == pol[POL_PE]);
    end
endmodule

// File: rtl/slfifo_lane.sv
// One FIFO channel: word storage, read/write pointers, occupancy, pending packet byte count.
// Refuses writes when full and reads when empty.
// Raises commit for the edge on which the pending packet closes.
// Assumes: at most one lane is enabled per cycle, and pkt_len stays stable while traffic flows.
module slfifo_lane #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LEN_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              pe_en,
    input  logic              wide,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              empty,
    output logic              full,
    output logic              commit,
    output logic [LEN_W:0]    commit_bytes
);
    localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
    localparam int unsigned HALF   = DATA_W / 2;
    localparam int unsigned PEND_W = LEN_W + 1;
    localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CFULL = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic [CNT_W-1:0]  count;
    logic [PEND_W-1:0] pend, new_pend, inc;
    logic              do_wr, do_rd;
    logic [DATA_W-1:0] wr_word;

    // Qualify strobes with occupancy and build the stored word and byte increment.
    always_comb begin
        empty    = (count == '0);
        full     = (count == CFULL);
        do_wr    = wr_en && !full;
        do_rd    = rd_en && !empty;
        wr_word  = wide ? din : {{(DATA_W-HALF){1'b0}}, din[HALF-1:0]};
        inc      = !do_wr ? '0 : (wide ? PEND_W'(2) : PEND_W'(1));
        new_pend = pend + inc;
        commit   = (new_pend != '0) && (pe_en || (new_pend >= {1'b0, pkt_len}));
        commit_bytes = new_pend;
        dout     = mem[rptr];
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_word;
    end

    // Pointer, occupancy and pending byte bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            pend  <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_rd) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            pend <= commit ? '0 : new_pend;
        end
    end

    AST_FULL_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en) |=> $stable(wptr)); // R6
    AST_EMPTY_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en) |=> $stable(rptr)); // R6
    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CFULL); // R11
    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (pend == '0)); // R7
endmodule

// File: rtl/slave_fifo_port.sv
// Synchronous slave port over four packet FIFOs.
// Decodes the strobes, steers them to the selected lane, muxes data and flags back,
// and registers a one-cycle commit event for the internal side.
// Assumes: all pins are synchronous to clk, and configuration changes only while idle.
module slave_fifo_port
    import slfifo_pkg::*;
#(
    parameter int unsigned NUM_FIFO = 4,
    parameter int unsigned DEPTH    = 8,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned LEN_W    = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [4:0]                   cfg_pol,
    input  logic                         cfg_cs_use,
    input  logic                         cfg_wide,
    input  logic [LEN_W-1:0]             cfg_pkt_len,
    input  logic [1:0]                   cfg_watch,
    input  logic [1:0]                   fifo_sel,
    input  logic                         sl_cs,
    input  logic                         sl_rd,
    input  logic                         sl_wr,
    input  logic                         sl_oe,
    input  logic                         sl_pktend,
    input  logic [DATA_W-1:0]            bus_in,
    output logic [DATA_W-1:0]            bus_out,
    output logic                         bus_drive,
    output logic                         flag_empty,
    output logic                         flag_full,
    output logic                         flag_watch,
    output logic                         commit_valid,
    output logic [1:0]                   commit_fifo,
    output logic [LEN_W:0]               commit_bytes
);
    localparam int unsigned SEL_W = $clog2(NUM_FIFO);

    strobe_t            act;
    logic [DATA_W-1:0]  lane_dout  [NUM_FIFO];
    logic [LEN_W:0]     lane_bytes [NUM_FIFO];
    logic [NUM_FIFO-1:0] lane_empty, lane_full, lane_commit;
    logic [SEL_W-1:0]   sel;

    assign sel = SEL_W'(fifo_sel);

    slfifo_strobe_decode u_dec (
        .pol    (cfg_pol),
        .cs_use (cfg_cs_use),
        .cs_pin (sl_cs),
        .rd_pin (sl_rd),
        .wr_pin (sl_wr),
        .oe_pin (sl_oe),
        .pe_pin (sl_pktend),
        .act    (act)
    );

    for (genvar g = 0; g < NUM_FIFO; g++) begin : g_lane
        logic hit;
        assign hit = (sel == SEL_W'(g));
        slfifo_lane #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_en        (hit && act.wr),
            .rd_en        (hit && act.rd),
            .pe_en        (hit && act.pe),
            .wide         (cfg_wide),
            .pkt_len      (cfg_pkt_len),
            .din          (bus_in),
            .dout         (lane_dout[g]),
            .empty        (lane_empty[g]),
            .full         (lane_full[g]),
            .commit       (lane_commit[g]),
            .commit_bytes (lane_bytes[g])
        );
    end

    // Output mux: data gated by output-enable, flags from the selected or watched lane.
    always_comb begin
        bus_drive  = act.oe;
        bus_out    = act.oe ? lane_dout[sel] : '0;
        flag_empty = lane_empty[sel];
        flag_full  = lane_full[sel];
        flag_watch = lane_full[SEL_W'(cfg_watch)];
    end

    // Commit event register toward the internal side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_valid <= 1'b0;
            commit_fifo  <= '0;
            commit_bytes <= '0;
        end else begin
            commit_valid <= lane_commit[sel];
            commit_fifo  <= fifo_sel;
            commit_bytes <= lane_bytes[sel];
        end
    end

    AST_COMMIT_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> (commit_bytes != '0)); // R7
    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_drive |-> (bus_out == '0)); // R5
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_empty && flag_full)); // R11
    AST_CS_GATES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cs_use && (sl_cs != cfg_pol[4])) |-> (!bus_drive && !lane_commit[sel])); // R10
endmodule

// File: tb/slave_fifo_port_tb.sv
module slave_fifo_port_tb;
    localparam int unsigned DEPTH = 8;
    localparam int unsigned LEN_W = 10;

    logic clk = 0;
    logic rst_n = 0;
    logic [4:0] cfg_pol = 5'b00000;
    logic cfg_cs_use = 0, cfg_wide = 1;
    logic [LEN_W-1:0] cfg_pkt_len = 10'd8;
    logic [1:0] cfg_watch = 2'd3, fifo_sel = 0;
    logic lcs = 0, lrd = 0, lwr = 0, loe = 0, lpe = 0;
    logic sl_cs, sl_rd, sl_wr, sl_oe, sl_pktend;
    logic [15:0] bus_in = 0, bus_out;
    logic bus_drive, flag_empty, flag_full, flag_watch, commit_valid;
    logic [1:0] commit_fifo;
    logic [LEN_W:0] commit_bytes;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    // Logical strobes mapped to pin levels by the configured polarity.
    always_comb begin
        sl_rd     = cfg_pol[0] ? lrd : ~lrd;
        sl_wr     = cfg_pol[1] ? lwr : ~lwr;
        sl_oe     = cfg_pol[2] ? loe : ~loe;
        sl_pktend = cfg_pol[3] ? lpe : ~lpe;
        sl_cs     = cfg_pol[4] ? lcs : ~lcs;
    end

    slave_fifo_port #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_pol(cfg_pol), .cfg_cs_use(cfg_cs_use),
        .cfg_wide(cfg_wide), .cfg_pkt_len(cfg_pkt_len), .cfg_watch(cfg_watch),
        .fifo_sel(fifo_sel), .sl_cs(sl_cs), .sl_rd(sl_rd), .sl_wr(sl_wr),
        .sl_oe(sl_oe), .sl_pktend(sl_pktend), .bus_in(bus_in), .bus_out(bus_out),
        .bus_drive(bus_drive), .flag_empty(flag_empty), .flag_full(flag_full),
        .flag_watch(flag_watch), .commit_valid(commit_valid),
        .commit_fifo(commit_fifo), .commit_bytes(commit_bytes)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d, input bit pe);
        @(negedge clk);
        fifo_sel = a; bus_in = d; lwr = 1; lpe = pe;
        @(posedge clk); #1;
        lwr = 0; lpe = 0;
    endtask

    task automatic rd(input logic [1:0] a);
        @(negedge clk);
        fifo_sel = a; lrd = 1;
        @(posedge clk); #1;
        lrd = 0;
    endtask

    task automatic pe_only(input logic [1:0] a);
        @(negedge clk);
        fifo_sel = a; lpe = 1;
        @(posedge clk); #1;
        lpe = 0;
    endtask

    task automatic peek(input logic [1:0] a);
        @(negedge clk);
        fifo_sel = a; loe = 1;
        #1;
    endtask

    task automatic t_reset();
        eq("R12 empty after reset", flag_empty, 1);
        eq("R12 full after reset", flag_full, 0);
        eq("R12 watch after reset", flag_watch, 0);
        eq("R12 no drive after reset", bus_drive, 0);
        eq("R12 no commit after reset", commit_valid, 0);
    endtask

    task automatic t_write_read();
        wr(0, 16'hA101, 0); wr(0, 16'hA102, 0); wr(0, 16'hA103, 0);
        eq("R3 no commit below length", commit_valid, 0);
        eq("R11 not empty", flag_empty, 0);
        peek(0);
        eq("R5 drive with oe", bus_drive, 1);
        eq("R4 head shown", bus_out, 16'hA101);
        @(negedge clk); #1;
        eq("R4 head held without read", bus_out, 16'hA101);
        rd(0);
        eq("R4 next word after read", bus_out, 16'hA102);
        @(negedge clk); loe = 0; #1;
        eq("R5 no drive without oe", bus_drive, 0);
        eq("R5 bus zero without oe", bus_out, 0);
        rd(0); rd(0);
        eq("R11 empty after drain", flag_empty, 1);
    endtask

    task automatic t_pktend();
        pe_only(0);
        eq("R7 commit valid", commit_valid, 1);
        eq("R7 commit fifo", commit_fifo, 0);
        eq("R7 commit bytes", commit_bytes, 6);
        pe_only(0);
        eq("R7 no commit when nothing pending", commit_valid, 0);
    endtask

    task automatic t_addr();
        wr(1, 16'h1111, 0); wr(2, 16'h2222, 0);
        peek(1); eq("R1 fifo1 data", bus_out, 16'h1111);
        peek(2); eq("R1 fifo2 data", bus_out, 16'h2222);
        peek(3); eq("R1 fifo3 empty flag", flag_empty, 1);
        peek(1); eq("R1 fifo1 flag", flag_empty, 0);
        loe = 0;
        rd(1); rd(2);
        eq("R1 fifo2 drained", flag_empty, 1);
    endtask

    task automatic t_auto();
        for (int i = 0; i < 3; i++) wr(3, 16'h3000 + 16'(i), 0);
        eq("R8 no commit before length", commit_valid, 0);
        wr(3, 16'h3003, 0);
        eq("R8 auto commit", commit_valid, 1);
        eq("R8 auto commit bytes", commit_bytes, 8);
        eq("R8 auto commit fifo", commit_fifo, 3);
        wr(3, 16'h3004, 0);
        eq("R8 pending restarts", commit_valid, 0);
        wr(3, 16'h3005, 1);
        eq("R8 write plus pktend one commit", commit_valid, 1);
        eq("R8 write plus pktend bytes", commit_bytes, 4);
        peek(3);
        for (int i = 0; i < 6; i++) begin
            eq("R4 ordered drain", bus_out, 16'h3000 + i);
            rd(3);
        end
        eq("R11 fifo3 empty", flag_empty, 1);
        loe = 0;
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) wr(3, 16'h4000 + 16'(i), 0);
        eq("R11 full flag", flag_full, 1);
        eq("R11 watch flag", flag_watch, 1);
        wr(3, 16'hDEAD, 0);
        eq("R6 still full", flag_full, 1);
        peek(0);
        eq("R11 full follows select", flag_full, 0);
        eq("R11 watch independent of select", flag_watch, 1);
        peek(3);
        for (int i = 0; i < DEPTH; i++) begin
            eq("R6 full write dropped", bus_out, 16'h4000 + i);
            rd(3);
        end
        eq("R6 empty after full drain", flag_empty, 1);
        rd(3);
        wr(3, 16'h5A5A, 0);
        eq("R6 one word after empty read", flag_full, 0);
        eq("R6 not empty", flag_empty, 0);
        eq("R6 empty read did not move pointer", bus_out, 16'h5A5A);
        rd(3);
        eq("R6 single word drained", flag_empty, 1);
        loe = 0;
    endtask

    task automatic t_narrow();
        cfg_wide = 0;
        wr(0, 16'hABCD, 0); wr(0, 16'h1234, 0); wr(0, 16'h5678, 1);
        eq("R2 narrow commit", commit_valid, 1);
        eq("R2 narrow byte count", commit_bytes, 3);
        peek(0); eq("R2 low byte only", bus_out, 16'h00CD);
        rd(0); eq("R2 second byte", bus_out, 16'h0034);
        rd(0); eq("R2 third byte", bus_out, 16'h0078);
        rd(0);
        loe = 0;
        cfg_wide = 1;
    endtask

    task automatic t_polarity();
        @(negedge clk); cfg_pol = 5'b11111;
        @(negedge clk); #1;
        eq("R9 idle inverted pins no drive", bus_drive, 0);
        eq("R9 idle no commit", commit_valid, 0);
        wr(1, 16'h9999, 1);
        eq("R9 active-high commit", commit_valid, 1);
        eq("R9 active-high bytes", commit_bytes, 4);
        peek(1); eq("R9 active-high data", bus_out, 16'h9999);
        rd(1); eq("R9 active-high read", flag_empty, 1);
        loe = 0;
        @(negedge clk); cfg_pol = 5'b00000;
    endtask

    task automatic t_cs();
        @(negedge clk); cfg_cs_use = 1; lcs = 0;
        wr(2, 16'h7777, 0);
        eq("R10 write blocked without cs", flag_empty, 1);
        peek(2); eq("R10 oe blocked without cs", bus_drive, 0);
        loe = 0; lcs = 1;
        wr(2, 16'h7777, 0);
        peek(2);
        eq("R10 cs active drive", bus_drive, 1);
        eq("R10 cs active data", bus_out, 16'h7777);
        rd(2);
        loe = 0; lcs = 0;
        @(negedge clk); cfg_cs_use = 0;
        peek(2); eq("R10 cs ignored when unused", bus_drive, 1);
        loe = 0;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk); #1;
        t_reset();
        t_write_read();
        t_pktend();
        t_addr();
        t_auto();
        t_full();
        t_narrow();
        t_polarity();
        t_cs();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule